// File: doc/BRIEF.md
# Serial Bit-Pattern Channel

This block drives a two-wire serial output: a data line and a clock line that it derives itself by dividing the system clock. Once enabled, it shifts out a seed word of programmable length, least significant bit first, and sends that seed a programmable number of times back to back. It then raises a one-cycle completion pulse and parks both wires. A polarity input selects which clock edge moves the data. The other edge is the one a receiver samples on.

Every setting is captured into the channel's own registers in the cycle it starts. A caller may therefore change the inputs freely while a run is under way. When the channel is idle, each wire rests at its own programmable level. Dropping the enable at any time parks the wires in that same cycle. The next enable begins again from the first bit of the first repetition.

Top module: `serpat_chan`

## Requirements
- R1: While enable is low, the clock wire equals the idle-clock input, the data wire equals the idle-data input, and the done pulse is 0.
- R2: While running, every level of the clock wire lasts exactly divider+1 system clock cycles. The first level after start equals the polarity bit, and the wire toggles at every level boundary.
- R3: The data wire changes only where the clock wire moves to the level equal to the polarity bit. With polarity 1 that is a rising edge; with polarity 0 it is a falling edge.
- R4: Bits go out least significant bit first. Seed bit 0 is on the data wire from the first running cycle. Seed bits 31:0 come from the low word input and bits 63:32 from the high word input.
- R5: A repetition carries length+1 bits (length field 0 to 63), after which bit 0 follows again.
- R6: The seed is sent repeat+1 times (repeat field 0 to 1023). A run therefore lasts 2*(divider+1)*(length+1)*(repeat+1) cycles.
- R7: In the cycle right after the last level of the last bit, done is 1 for exactly one cycle and both wires are at their idle levels.
- R8: After completion, with enable still held high, the wires stay idle and done stays 0. A new run needs enable to go low and then high again.
- R9: Lowering enable during a run sets both wires to their idle levels in the same cycle. The next enable restarts from bit 0 of repetition 0.
- R10: Divider, seed, length, repeat and polarity are captured when a run starts. Changing those inputs during the run has no effect on it.
- R11: If enable is lowered in the final cycle of a run, no done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable |
| prediv_i | input | 32 | Clock divider; each clock-wire level lasts this value plus one cycles |
| seed_lo_i | input | 32 | Seed bits 31:0 |
| seed_hi_i | input | 32 | Seed bits 63:32 |
| len_m1_i | input | 6 | Bits per repetition minus one |
| reps_m1_i | input | 10 | Repetitions minus one |
| pol_i | input | 1 | Data-change edge select (1: rising, 0: falling) |
| idle_clk_i | input | 1 | Clock wire level when idle |
| idle_dat_i | input | 1 | Data wire level when idle |
| sclk_o | output | 1 | Generated clock wire |
| sdat_o | output | 1 | Data wire |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Completion and disable can fall in the same cycle: the edge that ends the last bit of the last repetition can also be the edge at which enable is seen low. The bench provokes this by lowering enable in the final running cycle, computed as 2*(divider+1)*(length+1)*(repeat+1) minus one. It then requires that no done pulse follows and that both wires sit idle. A normal completion under the same settings is checked separately and must show the pulse.

// File: rtl/serpat_pkg.sv
package serpat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } serpat_state_e;
endpackage

// File: rtl/serpat_cfg_latch.sv
module serpat_cfg_latch #(
  parameter int DIV_W  = 32,
  parameter int SEED_W = 64,
  parameter int LEN_W  = 6,
  parameter int REP_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  prediv_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [REP_W-1:0]  reps_i,
  input  logic              pol_i,
  output logic [DIV_W-1:0]  prediv_o,
  output logic [SEED_W-1:0] seed_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [REP_W-1:0]  reps_o,
  output logic              pol_o
);
  logic [DIV_W-1:0]  prediv_q, prediv_d;
  logic [SEED_W-1:0] seed_q, seed_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [REP_W-1:0]  reps_q, reps_d;
  logic              pol_q, pol_d;

  always_comb begin
    prediv_d = prediv_q;
    seed_d   = seed_q;
    len_d    = len_q;
    reps_d   = reps_q;
    pol_d    = pol_q;
    if (load_i) begin
      prediv_d = prediv_i;
      seed_d   = seed_i;
      len_d    = len_i;
      reps_d   = reps_i;
      pol_d    = pol_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prediv_q <= '0;
      seed_q   <= '0;
      len_q    <= '0;
      reps_q   <= '0;
      pol_q    <= 1'b0;
    end else if (load_i) begin
      prediv_q <= prediv_d;
      seed_q   <= seed_d;
      len_q    <= len_d;
      reps_q   <= reps_d;
      pol_q    <= pol_d;
    end
  end

  assign prediv_o = prediv_q;
  assign seed_o   = seed_q;
  assign len_o    = len_q;
  assign reps_o   = reps_q;
  assign pol_o    = pol_q;

  // R10: captured settings do not move while a run continues
  assert_cfg_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> ($stable(prediv_q) && $stable(seed_q) &&
                                 $stable(len_q) && $stable(reps_q) && $stable(pol_q)));
endmodule

// File: rtl/serpat_divider.sv
module serpat_divider #(
  parameter int DIV_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             phase_o,
  output logic             bit_end_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             half_end;

  always_comb begin
    cnt_d    = cnt_q;
    ph_d     = ph_q;
    half_end = run_i && (cnt_q == limit_i);
    if (!run_i) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (half_end) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase_o   = ph_q;
  assign bit_end_o = half_end && ph_q;

  // R2: the level counter never passes the captured divider
  assert_div_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= limit_i));
  // R2: the phase flips only after a full level
  assert_phase_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (ph_q != $past(ph_q))) |-> ($past(cnt_q) == limit_i));
endmodule

// File: rtl/serpat_seq.sv
module serpat_seq
  import serpat_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int REP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_end_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [REP_W-1:0] reps_i,
  output logic             start_o,
  output logic             run_o,
  output logic [LEN_W-1:0] bit_o,
  output logic             done_o
);
  serpat_state_e    st_q, st_d;
  logic [LEN_W-1:0] bit_q, bit_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             done_q, done_d;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    rep_d  = rep_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (en_i) begin
          st_d  = ST_RUN;
          bit_d = '0;
          rep_d = '0;
        end
      end
      ST_RUN: begin
        if (!en_i) begin
          st_d = ST_IDLE;
        end else if (bit_end_i) begin
          if (bit_q == len_i) begin
            bit_d = '0;
            if (rep_q == reps_i) begin
              st_d   = ST_HOLD;
              done_d = 1'b1;
            end else begin
              rep_d = rep_q + 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (!en_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      rep_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      rep_q  <= rep_d;
      done_q <= done_d;
    end
  end

  assign start_o = (st_q == ST_IDLE) && en_i;
  assign run_o   = (st_q == ST_RUN);
  assign bit_o   = bit_q;
  assign done_o  = done_q;

  // R5: bit index stays inside the captured length
  assert_bit_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (bit_q <= len_i));
  // R6: repetition index stays inside the captured count
  assert_rep_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (rep_q <= reps_i));
  // R7: done only directly after a run, and never twice in a row
  assert_done_origin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(st_q) == ST_RUN) && $past(en_i));
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R11: disable seen at the last edge leaves no pulse
  assert_abort_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RUN) && !en_i) |=> !done_q);
endmodule

// File: rtl/serpat_chan.sv
module serpat_chan #(
  parameter int DIV_W  = 32,
  parameter int WORD_W = 32,
  parameter int REP_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  prediv_i,
  input  logic [WORD_W-1:0] seed_lo_i,
  input  logic [WORD_W-1:0] seed_hi_i,
  input  logic [$clog2(2*WORD_W)-1:0] len_m1_i,
  input  logic [REP_W-1:0]  reps_m1_i,
  input  logic              pol_i,
  input  logic              idle_clk_i,
  input  logic              idle_dat_i,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              done_o
);
  localparam int SEED_W = 2 * WORD_W;
  localparam int LEN_W  = $clog2(SEED_W);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic              start, run, phase, bit_end;
  logic [LEN_W-1:0]  bit_idx;
  logic [DIV_W-1:0]  prediv_q;
  logic [SEED_W-1:0] seed_q;
  logic [LEN_W-1:0]  len_q;
  logic [REP_W-1:0]  reps_q;
  logic              pol_q;
  logic              active;

  serpat_cfg_latch #(
    .DIV_W(DIV_W), .SEED_W(SEED_W), .LEN_W(LEN_W), .REP_W(REP_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (start),
    .run_i    (run),
    .prediv_i (prediv_i),
    .seed_i   ({seed_hi_i, seed_lo_i}),
    .len_i    (len_m1_i),
    .reps_i   (reps_m1_i),
    .pol_i    (pol_i),
    .prediv_o (prediv_q),
    .seed_o   (seed_q),
    .len_o    (len_q),
    .reps_o   (reps_q),
    .pol_o    (pol_q)
  );

  serpat_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .run_i     (run),
    .limit_i   (prediv_q),
    .phase_o   (phase),
    .bit_end_o (bit_end)
  );

  serpat_seq #(.LEN_W(LEN_W), .REP_W(REP_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .en_i      (en_i),
    .bit_end_i (bit_end),
    .len_i     (len_q),
    .reps_i    (reps_q),
    .start_o   (start),
    .run_o     (run),
    .bit_o     (bit_idx),
    .done_o    (done_o)
  );

  // enable gates the wires directly so a disable parks them at once
  assign active = run && en_i;
  assign sclk_o = active ? (phase ? ~pol_q : pol_q) : idle_clk_i;
  assign sdat_o = active ? seed_q[bit_idx] : idle_dat_i;

  // R3: data moves only together with a clock move onto the polarity level
  assert_data_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (active && $past(active) && (sdat_o != $past(sdat_o))) |->
      ((sclk_o == pol_q) && ($past(sclk_o) != pol_q)));
  // R1: wires idle whenever enable is low
  assert_idle_wires_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |-> ((sclk_o == idle_clk_i) && (sdat_o == idle_dat_i) && !done_o));
endmodule

// File: tb/serpat_chan_tb_top.sv
module serpat_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] prediv = '0;
  logic [31:0] seed_lo = '0;
  logic [31:0] seed_hi = '0;
  logic [5:0]  len_m1 = '0;
  logic [9:0]  reps_m1 = '0;
  logic        pol = 1'b0;
  logic        idle_clk = 1'b0;
  logic        idle_dat = 1'b0;
  logic        sclk, sdat, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serpat_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .prediv_i(prediv),
    .seed_lo_i(seed_lo), .seed_hi_i(seed_hi), .len_m1_i(len_m1),
    .reps_m1_i(reps_m1), .pol_i(pol), .idle_clk_i(idle_clk),
    .idle_dat_i(idle_dat), .sclk_o(sclk), .sdat_o(sdat), .done_o(done)
  );

  task automatic cmp(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {sclk,sdat,done} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // in-run expectation from the cycle count k since start
  function automatic logic [2:0] model(input int k, input int p, input int l,
                                       input logic pl, input logic [63:0] sd);
    int h, b;
    h = k / (p + 1);
    b = (h / 2) % (l + 1);
    return {pl ^ h[0], sd[b], 1'b0};
  endfunction

  // one complete run; chg_at >= 0 alters the inputs mid-run (R10)
  task automatic run_case(input int p, input int l, input int r, input logic pl,
                          input logic ic, input logic id, input logic [63:0] sd,
                          input int chg_at);
    int t;
    prediv = p; len_m1 = l[5:0]; reps_m1 = r[9:0]; pol = pl;
    idle_clk = ic; idle_dat = id; seed_lo = sd[31:0]; seed_hi = sd[63:32];
    en = 1'b0;
    tick();
    cmp("R1 idle while disabled", {sclk, sdat, done}, {ic, id, 1'b0});
    en = 1'b1;
    #1;
    cmp("R1 idle before first edge", {sclk, sdat, done}, {ic, id, 1'b0});
    t = 2 * (p + 1) * (l + 1) * (r + 1);
    for (int k = 0; k < t; k++) begin
      tick();
      // R2 clock levels, R3 edge choice, R4 bit order, R5 wrap, R6 length
      cmp("R2 R3 R4 R5 R6 running", {sclk, sdat, done}, model(k, p, l, pl, sd));
      if (k == chg_at) begin
        prediv = prediv + 3; len_m1 = ~len_m1; reps_m1 = reps_m1 + 5;
        pol = ~pol; seed_lo = ~seed_lo; seed_hi = ~seed_hi;
      end
    end
    tick();
    cmp("R7 done pulse", {sclk, sdat, done}, {ic, id, 1'b1});
    for (int k = 0; k < 3; k++) begin
      tick();
      cmp("R8 quiet after done", {sclk, sdat, done}, {ic, id, 1'b0});
    end
    en = 1'b0;
  endtask

  // start, run to cycle a, lower enable and check idle at once
  task automatic abort_case(input int p, input int l, input int r, input logic pl,
                            input logic ic, input logic id, input logic [63:0] sd,
                            input int a, input string tag);
    prediv = p; len_m1 = l[5:0]; reps_m1 = r[9:0]; pol = pl;
    idle_clk = ic; idle_dat = id; seed_lo = sd[31:0]; seed_hi = sd[63:32];
    en = 1'b0;
    tick();
    en = 1'b1;
    for (int k = 0; k <= a; k++) begin
      tick();
      cmp("R9 running before abort", {sclk, sdat, done}, model(k, p, l, pl, sd));
    end
    en = 1'b0;
    #1;
    cmp(tag, {sclk, sdat, done}, {ic, id, 1'b0});
    for (int k = 0; k < 3; k++) begin
      tick();
      cmp(tag, {sclk, sdat, done}, {ic, id, 1'b0});
    end
  endtask

  function automatic logic [63:0] mk_seed(input int i);
    logic [63:0] v;
    v = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1);
    return v ^ {v[31:0], v[63:32]};
  endfunction

  initial begin
    #(20 * 190000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int idx;
    int lens[4];
    lens[0] = 0; lens[1] = 1; lens[2] = 6; lens[3] = 63;
    repeat (3) tick();
    // reset state, R1
    cmp("R1 during reset", {sclk, sdat, done}, 3'b000);
    rst_n = 1'b1;
    repeat (4) tick();
    idle_clk = 1'b1; idle_dat = 1'b0;
    #1;
    cmp("R1 idle levels follow inputs", {sclk, sdat, done}, 3'b100);

    // sweep: polarity x divider x length x repeats, idle levels varied
    idx = 0;
    for (int pl = 0; pl < 2; pl++)
      for (int pi = 0; pi < 2; pi++)
        for (int li = 0; li < 4; li++)
          for (int ri = 0; ri < 2; ri++) begin
            run_case(pi * 2, lens[li], ri * 3, pl[0], pl[0] ^ lens[li][0],
                     ri[0] ^ pi[0], mk_seed(idx), -1);
            idx++;
          end

    // R4: distinct words, word boundary crossed at bit 32
    run_case(0, 63, 0, 1'b1, 1'b0, 1'b1, {32'h0000_0001, 32'h8000_0000}, -1);
    // R6: largest repeat count with a one-bit seed
    run_case(0, 0, 1023, 1'b0, 1'b1, 1'b1, 64'h1, -1);
    // R2: wider divider
    run_case(6, 3, 1, 1'b1, 1'b0, 1'b0, 64'h5, -1);
    // R10: inputs changed mid-run leave the run untouched
    run_case(1, 6, 2, 1'b0, 1'b0, 1'b1, mk_seed(77), 9);
    run_case(0, 5, 1, 1'b1, 1'b1, 1'b0, mk_seed(78), 0);

    // R9: disable mid-run, then full restart from bit 0
    abort_case(1, 9, 2, 1'b1, 1'b0, 1'b1, mk_seed(90), 17, "R9 abort parks wires");
    run_case(1, 9, 2, 1'b1, 1'b0, 1'b1, mk_seed(90), -1);
    abort_case(0, 3, 0, 1'b0, 1'b1, 1'b1, mk_seed(91), 0, "R9 abort first cycle");
    run_case(0, 3, 0, 1'b0, 1'b1, 1'b1, mk_seed(91), -1);

    // R11: disable in the very last running cycle -> no done
    abort_case(1, 2, 1, 1'b1, 1'b0, 1'b0, mk_seed(95), 2*2*3*2 - 1,
               "R11 no done on last-cycle disable");
    abort_case(0, 0, 0, 1'b0, 1'b1, 1'b0, mk_seed(96), 1,
               "R11 no done on last-cycle disable");
    run_case(1, 2, 1, 1'b1, 1'b0, 1'b0, mk_seed(95), -1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule